// File: doc/BRIEF.md
# Calendar Clock with Scratch Storage

This block keeps time of day and calendar date for a host that reaches it through a 128-location byte-wide register window. A one-hertz tick drives a counting chain that runs from seconds through minutes, hours, day of week and day of month, then month, then a two-digit year. The host reads and writes every value as BCD. The host can pick a 12-hour view of the hour, with a PM flag in bit 7, or a 24-hour view. An optional daylight-saving rule moves the clock forward one hour in spring and back one hour in autumn, and February gets its extra day in leap years.

The lowest 14 locations hold the time, the alarm, control, flags and status. The other 114 locations are plain scratch bytes that keep their contents. A status bit tells the host whether it can trust the time and the scratch bytes: it clears when backup power is lost, and only a host write sets it again. An interrupt line is raised by an alarm match or by the end of an update, and reading the flag register drops it.

The update sequencer is a four-state machine:
- `S_IDLE`: waits for a tick.
- `S_FROZEN`: the host holds the clock to write time.
- `S_ADVANCE`: loads the next time.
- `S_REPORT`: raises the update-ended event and checks the alarm.

Its transitions are:
- IDLE→FROZEN when hold is set.
- IDLE→ADVANCE when a tick is pending and hold is clear.
- FROZEN→IDLE when hold clears.
- ADVANCE→REPORT always.
- REPORT→IDLE always.

Top module: `rtc_calendar_top`

## Requirements
- R1: After reset the clock reads 00:00:00 with day of week 01, date 01, month 01 and year 00. Control reads 0x00, so the clock is in 24-hour mode with every option off. Status reads 0x00 and irq is low.
- R2: Each accepted tick adds one second. The carry runs through minutes, hours (0x00–0x23), day of week (0x01–0x07, wrapping 7→1 at midnight), date, month (0x01–0x12) and year (0x00–0x99, wrapping to 0x00).
- R3: April, June, September and November have 30 days. February has 28 days, or 29 when the year is a multiple of 4 (year 00 included). All other months have 31.
- R4: Control bit 0 set selects 12-hour mode. In that mode the hour reads and is written as BCD 0x01–0x12 with bit 7 = PM. Midnight reads 0x12 and noon reads 0x92.
- R5: Control bit 1 enables daylight saving. In month 4 on day-of-week 1 with date ≥ 24, the step past 01:59:59 goes to 03:00:00. With the bit clear, or on an earlier date, it goes to 02:00:00.
- R6: With control bit 1 set, in month 10 on day-of-week 1 with date ≥ 25, the step past 01:59:59 goes to 01:00:00. This repeat happens only once per day, so the next pass through 01:59:59 goes to 02:00:00.
- R7: Control bit 2 (hold) stops counting. One tick that arrives during hold is applied after hold clears. Time locations 0–6 accept writes only while the clock is held, and writes at other times are ignored.
- R8: Status bit 0 (update in progress) is 1 during the two cycles of an update and 0 otherwise.
- R9: Every update sets flag bit 0. An update whose new seconds, minutes and hour equal alarm locations 7, 8 and 9 also sets flag bit 1. irq is high when (bit 1 AND control bit 3) OR (bit 0 AND control bit 4). Location 11 reads {irq, 00000, bit 1, bit 0}, and reading it clears both flags and drops irq.
- R10: Status bit 7 (valid) is 0 after reset and after a backup_lost pulse. It changes only when the host writes location 12 bit 7.
- R11: Locations 14–127 are 114 scratch bytes that read back what was last written. Location 13 reads 0x00.
- R12: rdata changes at the clock edge that samples rd_en and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| backup_lost | input | 1 | Pulse marking loss of backup power |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 7 | Register location |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest cases to reach are the daylight-saving steps, because they need a Sunday near the end of April or October at 01:59:59 and then one more second. The bench reaches them by holding the clock, loading each register with exactly that moment, releasing hold and sending one tick. The one-repeat rule is checked by loading 01:59:59 again on the same date straight after the autumn step. The update-in-progress bit lasts only two cycles, so the bench places a read strobe so that its capturing edge falls inside that window.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int RTC_AW        = 7;
    localparam int RTC_DW        = 8;
    localparam int RTC_CLK_REGS  = 14;
    localparam int RTC_RAM_WORDS = (1 << RTC_AW) - RTC_CLK_REGS;

    typedef logic [RTC_AW-1:0] rtc_addr_t;

    localparam rtc_addr_t A_SEC      = 7'd0;
    localparam rtc_addr_t A_MIN      = 7'd1;
    localparam rtc_addr_t A_HOUR     = 7'd2;
    localparam rtc_addr_t A_DOW      = 7'd3;
    localparam rtc_addr_t A_DATE     = 7'd4;
    localparam rtc_addr_t A_MONTH    = 7'd5;
    localparam rtc_addr_t A_YEAR     = 7'd6;
    localparam rtc_addr_t A_ALM_SEC  = 7'd7;
    localparam rtc_addr_t A_ALM_MIN  = 7'd8;
    localparam rtc_addr_t A_ALM_HOUR = 7'd9;
    localparam rtc_addr_t A_CTRL     = 7'd10;
    localparam rtc_addr_t A_FLAGS    = 7'd11;
    localparam rtc_addr_t A_STATUS   = 7'd12;
    localparam rtc_addr_t A_SPARE    = 7'd13;
    localparam rtc_addr_t A_RAM_BASE = 7'(RTC_CLK_REGS);

    localparam int C_MODE12 = 0;
    localparam int C_DST    = 1;
    localparam int C_HOLD   = 2;
    localparam int C_AIE    = 3;
    localparam int C_UIE    = 4;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] month;
        logic [4:0] date;
        logic [2:0] dow;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } rtc_time_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FROZEN,
        S_ADVANCE,
        S_REPORT
    } upd_state_e;

    function automatic logic [7:0] bin2bcd(input logic [6:0] v);
        logic [7:0] w;
        w = {1'b0, v};
        return ((w / 8'd10) << 4) | (w % 8'd10);
    endfunction

    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        return {3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]};
    endfunction

    function automatic logic [4:0] days_in_month(input logic [3:0] mon, input logic leap);
        case (mon)
            4'd2:                      return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_scratch_ram.sv
module rtc_scratch_ram #(
    parameter int WORDS = 114,
    parameter int AW    = 7,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/rtc_update_fsm.sv
module rtc_update_fsm
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      hold,
    input  logic      dst_en,
    input  logic      host_wr,
    input  rtc_time_t host_time,
    output rtc_time_t cur_o,
    output logic      uip_o,
    output logic      frozen_o,
    output logic      upd_done_o
);
    upd_state_e state_q, state_d;
    rtc_time_t  cur_q, nxt;
    logic       pending_q, back_done_q, nxt_back;
    logic       dst_fwd, dst_back, consume;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (hold)           state_d = S_FROZEN;
                else if (pending_q) state_d = S_ADVANCE;
            end
            S_FROZEN:  if (!hold) state_d = S_IDLE;
            S_ADVANCE: state_d = S_REPORT;
            S_REPORT:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        uip_o      = (state_q == S_ADVANCE) || (state_q == S_REPORT);
        frozen_o   = (state_q == S_FROZEN);
        upd_done_o = (state_q == S_REPORT);
    end

    assign consume = (state_q == S_IDLE) && (state_d == S_ADVANCE);
    assign cur_o   = cur_q;

    // next-second calculation
    always_comb begin
        nxt      = cur_q;
        nxt_back = back_done_q;
        dst_fwd  = dst_en && cur_q.hour == 5'd1 && cur_q.month == 4'd4
                   && cur_q.dow == 3'd1 && cur_q.date >= 5'd24;
        dst_back = dst_en && cur_q.hour == 5'd1 && cur_q.month == 4'd10
                   && cur_q.dow == 3'd1 && cur_q.date >= 5'd25 && !back_done_q;
        if (cur_q.sec != 6'd59) begin
            nxt.sec = cur_q.sec + 6'd1;
        end else begin
            nxt.sec = '0;
            if (cur_q.min != 6'd59) begin
                nxt.min = cur_q.min + 6'd1;
            end else begin
                nxt.min = '0;
                if (dst_fwd) begin
                    nxt.hour = 5'd3;
                end else if (dst_back) begin
                    nxt.hour = 5'd1;
                    nxt_back = 1'b1;
                end else if (cur_q.hour != 5'd23) begin
                    nxt.hour = cur_q.hour + 5'd1;
                end else begin
                    nxt.hour = '0;
                    nxt_back = 1'b0;
                    nxt.dow  = (cur_q.dow >= 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
                    if (cur_q.date >= days_in_month(cur_q.month, cur_q.year[1:0] == 2'b00)) begin
                        nxt.date = 5'd1;
                        if (cur_q.month >= 4'd12) begin
                            nxt.month = 4'd1;
                            nxt.year  = (cur_q.year >= 7'd99) ? 7'd0 : cur_q.year + 7'd1;
                        end else begin
                            nxt.month = cur_q.month + 4'd1;
                        end
                    end else begin
                        nxt.date = cur_q.date + 5'd1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '{year: 7'd0, month: 4'd1, date: 5'd1, dow: 3'd1,
                             hour: 5'd0, min: 6'd0, sec: 6'd0};
            pending_q   <= 1'b0;
            back_done_q <= 1'b0;
        end else begin
            pending_q <= tick | (pending_q & ~consume);
            if (state_q == S_ADVANCE) begin
                cur_q       <= nxt;
                back_done_q <= nxt_back;
            end else if (host_wr && state_q == S_FROZEN) begin
                cur_q <= host_time;
            end
        end
    end

    // R7: a held clock keeps its value unless the host writes it
    a_r7_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FROZEN && !host_wr) |=> $stable(cur_q));
    // R2: every advance produces a different time
    a_r2_advance_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADVANCE) |=> (cur_q != $past(cur_q)));
    // R8: update-ended is always preceded by the in-progress window
    a_r8_done_after_uip: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done_o |-> $past(uip_o));
endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1hz,
    input  logic        backup_lost,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [6:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        irq
);
    rtc_time_t cur, host_time;
    logic      uip, frozen, upd_done, time_wr;
    logic [4:0] ctrl_q;
    logic [7:0] alm_sec_q, alm_min_q, alm_hour_q;
    logic       uf_q, af_q, valid_q;
    logic [7:0] rdata_q, rd_mux, ram_rd;
    logic [7:0] sec_b, min_b, hour_b, dow_b, date_b, month_b, year_b;
    logic [6:0] hr_in, hr24_in;
    logic [6:0] ram_idx;
    logic       ram_we, alarm_hit, flags_rd;

    assign time_wr = wr_en && ctrl_q[C_HOLD] && (addr <= A_YEAR);

    rtc_update_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_1hz),
        .hold       (ctrl_q[C_HOLD]),
        .dst_en     (ctrl_q[C_DST]),
        .host_wr    (time_wr),
        .host_time  (host_time),
        .cur_o      (cur),
        .uip_o      (uip),
        .frozen_o   (frozen),
        .upd_done_o (upd_done)
    );

    assign ram_we  = wr_en && (addr >= A_RAM_BASE);
    assign ram_idx = addr - A_RAM_BASE;

    rtc_scratch_ram #(.WORDS(RTC_RAM_WORDS), .AW(RTC_AW), .DW(RTC_DW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (ram_idx),
        .wdata (wdata),
        .rdata (ram_rd)
    );

    // BCD view of the running time
    always_comb begin
        sec_b   = bin2bcd({1'b0, cur.sec});
        min_b   = bin2bcd({1'b0, cur.min});
        dow_b   = bin2bcd({4'b0, cur.dow});
        date_b  = bin2bcd({2'b0, cur.date});
        month_b = bin2bcd({3'b0, cur.month});
        year_b  = bin2bcd(cur.year);
        if (!ctrl_q[C_MODE12])         hour_b = bin2bcd({2'b0, cur.hour});
        else if (cur.hour == 5'd0)     hour_b = 8'h12;
        else if (cur.hour < 5'd12)     hour_b = bin2bcd({2'b0, cur.hour});
        else if (cur.hour == 5'd12)    hour_b = 8'h92;
        else                           hour_b = 8'h80 | bin2bcd({2'b0, cur.hour - 5'd12});
    end

    // host BCD write converted into the binary time record
    always_comb begin
        hr_in = bcd2bin({3'b000, wdata[4:0]});
        if (!ctrl_q[C_MODE12])   hr24_in = bcd2bin({2'b00, wdata[5:0]});
        else if (hr_in == 7'd12) hr24_in = wdata[7] ? 7'd12 : 7'd0;
        else                     hr24_in = wdata[7] ? hr_in + 7'd12 : hr_in;
        host_time = cur;
        case (addr)
            A_SEC:   host_time.sec   = 6'(bcd2bin(wdata));
            A_MIN:   host_time.min   = 6'(bcd2bin(wdata));
            A_HOUR:  host_time.hour  = 5'(hr24_in);
            A_DOW:   host_time.dow   = 3'(bcd2bin(wdata));
            A_DATE:  host_time.date  = 5'(bcd2bin(wdata));
            A_MONTH: host_time.month = 4'(bcd2bin(wdata));
            A_YEAR:  host_time.year  = bcd2bin(wdata);
            default: ;
        endcase
    end

    assign alarm_hit = (sec_b == alm_sec_q) && (min_b == alm_min_q) && (hour_b == alm_hour_q);
    assign irq       = (af_q & ctrl_q[C_AIE]) | (uf_q & ctrl_q[C_UIE]);
    assign flags_rd  = rd_en && (addr == A_FLAGS);

    always_comb begin
        case (addr)
            A_SEC:      rd_mux = sec_b;
            A_MIN:      rd_mux = min_b;
            A_HOUR:     rd_mux = hour_b;
            A_DOW:      rd_mux = dow_b;
            A_DATE:     rd_mux = date_b;
            A_MONTH:    rd_mux = month_b;
            A_YEAR:     rd_mux = year_b;
            A_ALM_SEC:  rd_mux = alm_sec_q;
            A_ALM_MIN:  rd_mux = alm_min_q;
            A_ALM_HOUR: rd_mux = alm_hour_q;
            A_CTRL:     rd_mux = {3'b000, ctrl_q};
            A_FLAGS:    rd_mux = {irq, 5'b00000, af_q, uf_q};
            A_STATUS:   rd_mux = {valid_q, 6'b000000, uip};
            A_SPARE:    rd_mux = 8'h00;
            default:    rd_mux = ram_rd;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            alm_sec_q  <= '0;
            alm_min_q  <= '0;
            alm_hour_q <= '0;
            uf_q       <= 1'b0;
            af_q       <= 1'b0;
            valid_q    <= 1'b0;
            rdata_q    <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    A_ALM_SEC:  alm_sec_q  <= wdata;
                    A_ALM_MIN:  alm_min_q  <= wdata;
                    A_ALM_HOUR: alm_hour_q <= wdata;
                    A_CTRL:     ctrl_q     <= wdata[4:0];
                    A_STATUS:   valid_q    <= wdata[7];
                    default: ;
                endcase
            end
            if (backup_lost) valid_q <= 1'b0;
            if (upd_done) begin
                uf_q <= 1'b1;
                if (alarm_hit) af_q <= 1'b1;
            end else if (flags_rd) begin
                uf_q <= 1'b0;
                af_q <= 1'b0;
            end
            if (rd_en) rdata_q <= rd_mux;
        end
    end

    assign rdata = rdata_q;

    // R9: a flag read with no simultaneous update leaves irq low
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd && !upd_done) |=> !irq);
    // R10: backup loss always invalidates
    a_r10_lost_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        backup_lost |=> !valid_q);
    // R7: no update runs while the host holds the clock
    a_r7_held_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !uip);
endmodule

// File: tb/rtc_calendar_top_tb.sv
module rtc_calendar_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 15;

    // {req, ctrl, start s m h dow date mon yr, expected s m h dow date mon yr}
    localparam logic [127:0] VEC [NVEC] = '{
        128'h02_00_05_00_00_01_01_01_00_06_00_00_01_01_01_00, // R2 seconds
        128'h02_00_59_00_00_01_01_01_00_00_01_00_01_01_01_00, // R2 minute carry
        128'h02_00_59_59_23_07_31_12_99_00_00_00_01_01_01_00, // R2 full wrap
        128'h03_00_59_59_23_03_28_02_23_00_00_00_04_01_03_23, // R3 Feb plain
        128'h03_00_59_59_23_03_28_02_24_00_00_00_04_29_02_24, // R3 Feb leap
        128'h03_00_59_59_23_04_29_02_24_00_00_00_05_01_03_24, // R3 Feb 29 end
        128'h03_00_59_59_23_02_30_04_25_00_00_00_03_01_05_25, // R3 30-day month
        128'h04_01_59_59_11_02_10_06_25_00_00_92_02_10_06_25, // R4 to noon
        128'h04_01_59_59_92_02_10_06_25_00_00_81_02_10_06_25, // R4 noon to 1 PM
        128'h04_01_59_59_91_02_10_06_25_00_00_12_03_11_06_25, // R4 to midnight
        128'h04_01_59_59_12_02_10_06_25_00_00_01_02_10_06_25, // R4 12 AM to 1 AM
        128'h05_02_59_59_01_01_28_04_24_00_00_03_01_28_04_24, // R5 spring jump
        128'h05_02_59_59_01_01_21_04_24_00_00_02_01_21_04_24, // R5 early Sunday
        128'h05_00_59_59_01_01_28_04_24_00_00_02_01_28_04_24, // R5 disabled
        128'h06_02_59_59_01_01_27_10_24_00_00_01_01_27_10_24  // R6 autumn repeat
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       backup_lost = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .backup_lost(backup_lost),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] ctrl, input logic [55:0] t);
        wr(7'd10, ctrl | 8'h04);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 7; i++) wr(7'(i), t[55-8*i -: 8]);
        wr(7'd10, ctrl);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [7:0] d, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "irq", {7'd0, irq}, 8'h00);
        rd(7'd0, d);  chk("R1", "sec", d, 8'h00);
        rd(7'd2, d);  chk("R1", "hour", d, 8'h00);
        rd(7'd3, d);  chk("R1", "dow", d, 8'h01);
        rd(7'd4, d);  chk("R1", "date", d, 8'h01);
        rd(7'd5, d);  chk("R1", "month", d, 8'h01);
        rd(7'd6, d);  chk("R1", "year", d, 8'h00);
        rd(7'd10, d); chk("R1", "ctrl", d, 8'h00);
        rd(7'd12, d); chk("R1", "status", d, 8'h00);

        // table of rollover vectors
        for (int v = 0; v < NVEC; v++) begin
            set_time(VEC[v][119:112], VEC[v][111:56]);
            tick();
            for (int i = 0; i < 7; i++) begin
                rd(7'(i), d);
                n_checks++;
                if (d !== VEC[v][55-8*i -: 8]) begin
                    n_fail++;
                    $display("FAIL R%0d vector %0d field %0d: actual %h expected %h",
                             VEC[v][127:120], v, i, d, VEC[v][55-8*i -: 8]);
                end
            end
        end

        // R6 second pass through 01:59:59 on the same day is not repeated
        set_time(8'h02, 56'h59_59_01_01_27_10_24);
        tick();
        rd(7'd2, d); chk("R6", "no second repeat hour", d, 8'h02);

        // R11 scratch bytes and spare location
        wr(7'd14, 8'hA5); wr(7'd127, 8'h3C); wr(7'd60, 8'h77);
        rd(7'd14, d);  chk("R11", "ram 14", d, 8'hA5);
        rd(7'd60, d);  chk("R11", "ram 60", d, 8'h77);
        rd(7'd127, d); chk("R11", "ram 127", d, 8'h3C);
        rd(7'd13, d);  chk("R11", "spare", d, 8'h00);

        // R12 read latency: rdata holds until the sampling edge
        @(negedge clk); rd_en = 1'b1; addr = 7'd14;
        chk("R12", "before edge", rdata, 8'h00);
        @(negedge clk); rd_en = 1'b0;
        chk("R12", "after edge", rdata, 8'hA5);
        @(negedge clk);
        chk("R12", "held", rdata, 8'hA5);

        // R7 held tick is kept and applied after release
        set_time(8'h00, 56'h00_00_08_02_10_06_25);
        wr(7'd10, 8'h04);
        repeat (2) @(negedge clk);
        wr(7'd0, 8'h10);
        tick();
        rd(7'd0, d); chk("R7", "held sec", d, 8'h10);
        wr(7'd10, 8'h00);
        repeat (6) @(negedge clk);
        rd(7'd0, d); chk("R7", "released sec", d, 8'h11);
        // R7 write while running is ignored
        rd(7'd0, prev);
        wr(7'd0, 8'h45);
        rd(7'd0, d); chk("R7", "ignored write", d, prev);

        // R8 update-in-progress window
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        @(negedge clk); rd_en = 1'b1; addr = 7'd12;
        @(negedge clk); rd_en = 1'b0;
        chk("R8", "uip during update", rdata & 8'h01, 8'h01);
        repeat (4) @(negedge clk);
        rd(7'd12, d); chk("R8", "uip idle", d & 8'h01, 8'h00);

        // R9 alarm and update interrupts
        set_time(8'h00, 56'h30_20_10_02_10_06_25);
        wr(7'd7, 8'h31); wr(7'd8, 8'h20); wr(7'd9, 8'h10);
        rd(7'd11, d);
        wr(7'd10, 8'h08);
        tick();
        chk("R9", "alarm irq", {7'd0, irq}, 8'h01);
        rd(7'd11, d); chk("R9", "flags alarm", d, 8'h83);
        chk("R9", "irq after read", {7'd0, irq}, 8'h00);
        wr(7'd10, 8'h10);
        tick();
        chk("R9", "update irq", {7'd0, irq}, 8'h01);
        rd(7'd11, d); chk("R9", "flags update", d, 8'h81);
        wr(7'd10, 8'h00);
        tick();
        chk("R9", "masked irq", {7'd0, irq}, 8'h00);
        rd(7'd11, d); chk("R9", "flags masked", d, 8'h01);

        // R10 validity bit
        rd(7'd12, d); chk("R10", "valid after reset", d & 8'h80, 8'h00);
        wr(7'd12, 8'h80);
        rd(7'd12, d); chk("R10", "valid after write", d & 8'h80, 8'h80);
        @(negedge clk); backup_lost = 1'b1;
        @(negedge clk); backup_lost = 1'b0;
        rd(7'd12, d); chk("R10", "valid after loss", d & 8'h80, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule